// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a peripheral. A bus master uses it to read and write a byte-wide register file that lives outside the block. It watches oversampled SCL and SDA lines and finds START, repeated START and STOP. It compares the 7-bit device address and acknowledges a match. It answers on SDA only through an open-drain output enable. The register file is reached through a pointer output, a write strobe with write data, and a combinational read-data input.

A write transfer sends a device address, then one pointer byte, then any number of data bytes. A read transfer first sets the pointer with a write that has no STOP. A repeated START follows, then the address with the read direction bit. The block then shifts out register contents until the master declines a byte. Only inside the configured address windows does the pointer step forward after each byte. Elsewhere it stays put, so a register can be read or written many times in one burst.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address is 0x40 when `strap_i` is 0 and 0x41 when it is 1. `strap_i` is sampled once, in the first clock after reset release. A matching address byte is acknowledged by pulling SDA low (`sda_oe_o`=1) during the ninth SCL clock.
- R2: If the address does not match, the block acknowledges nothing and writes nothing until the next START.
- R3: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Bytes clocked before any START, or after a STOP, are ignored and not acknowledged.
- R4: SDA is sampled on SCL rising edges. `sda_oe_o` changes only while the synchronized SCL is low.
- R5: In a write, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer with a single-cycle `reg_we_o` pulse, and each is acknowledged.
- R6: A repeated START followed by the matching address with direction bit 1 makes the block shift out the byte at the pointer, MSB first. A 0 bit is driven as `sda_oe_o`=1, and a 1 bit releases the line.
- R7: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A non-acknowledge makes it release SDA and stay idle until the next START.
- R8: A pointer in 0x00–0x3F or 0x80–0xFF advances by one after each byte read or written.
- R9: A pointer in 0x40–0x7F stays fixed for the whole burst.
- R10: Advancing from 0xFF gives 0x00.
- R11: After reset, `sda_oe_o`=0, `reg_we_o`=0 and `reg_addr_o`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Address LSB strap, sampled after reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o` |

## Verification
The assertions assume that SCL and SDA are stable for several system clocks around every edge, so the two-stage synchronizer never sees SCL change twice within one cycle. They also assume the master never raises START or STOP while the slave is pulling SDA low, and that it changes SDA only while SCL is low. The bench drives SCL as a master would and holds each phase for six system clocks. It changes its SDA only at the middle of the SCL low phase. The bus line is the wired AND of the master's SDA and the slave's output enable, which keeps all stimulus inside these assumptions.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_PREACK, ST_ACK, ST_TX, ST_MACK, ST_RDNEXT
  } state_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_REG, PH_DATA
  } phase_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr
  import i2c_rs_pkg::*;
#(
  parameter int NUM_RNG = 2,
  parameter logic [NUM_RNG*ADDR_W-1:0] RNG_LO = {8'h80, 8'h00},
  parameter logic [NUM_RNG*ADDR_W-1:0] RNG_HI = {8'hFF, 8'h3F}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic [NUM_RNG-1:0] hit;

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    localparam logic [ADDR_W-1:0] LO   = RNG_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = RNG_HI[g*ADDR_W +: ADDR_W] - LO;
    logic [ADDR_W-1:0] off;
    assign off    = ptr_q - LO;
    assign hit[g] = off <= SPAN;
  end

  logic in_rng;
  assign in_rng = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= '0;
    else if (load_i)           ptr_q <= load_val_i;
    else if (adv_i && in_rng)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + ADDR_W'(1);
  end

  assign ptr_o = ptr_q;

  a_r8_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && in_rng && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));
  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !in_rng) |=> $stable(ptr_q));
  a_r10_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && in_rng && ptr_q == LAST) |=> ptr_q == '0);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter logic [5:0] DEV_HI  = 6'h20,
  parameter int         SYNC_N  = 2,
  parameter int         NUM_RNG = 2,
  parameter logic [NUM_RNG*ADDR_W-1:0] RNG_LO = {8'h80, 8'h00},
  parameter logic [NUM_RNG*ADDR_W-1:0] RNG_HI = {8'hFF, 8'h3F}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rs_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  state_e state_q;
  phase_e phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic rw_q, match_q, strap_q, strap_done_q;

  // strap captured once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_i;
      strap_done_q <= 1'b1;
    end
  end

  logic byte_end, ptr_load, ptr_adv;
  logic [BYTE_W-1:0] rx_byte;
  assign rx_byte  = {sh_q[BYTE_W-2:0], sda_s};
  assign byte_end = (state_q == ST_RX) && scl_rise && (cnt_q == LAST_BIT) && !start_det && !stop_det;
  assign ptr_load = byte_end && (phase_q == PH_REG);
  assign reg_we_o = byte_end && (phase_q == PH_DATA);
  assign ptr_adv  = reg_we_o ||
                    ((state_q == ST_TX) && scl_fall && (cnt_q == ALL_BITS) && !start_det && !stop_det);
  assign reg_wdata_o = rx_byte;

  i2c_rs_ptr #(.NUM_RNG(NUM_RNG), .RNG_LO(RNG_LO), .RNG_HI(RNG_HI)) i_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(rx_byte), .adv_i(ptr_adv), .ptr_o(reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      match_q <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_RX;
      phase_q <= PH_DEV;
      cnt_q   <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RX: if (scl_rise) begin
          sh_q <= rx_byte;
          if (cnt_q == LAST_BIT) begin
            cnt_q   <= '0;
            state_q <= ST_PREACK;
            if (phase_q == PH_DEV) begin
              match_q <= (sh_q[BYTE_W-2:0] == {DEV_HI, strap_q});
              rw_q    <= sda_s;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PREACK: if (scl_fall)
          state_q <= (phase_q == PH_DEV && !match_q) ? ST_IDLE : ST_ACK;
        ST_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (phase_q == PH_DEV && rw_q) begin
            sh_q    <= reg_rdata_i;
            state_q <= ST_TX;
          end else begin
            phase_q <= (phase_q == PH_DEV) ? PH_REG : PH_DATA;
            state_q <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == ALL_BITS) begin
              state_q <= ST_MACK;
              cnt_q   <= '0;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_MACK: if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_RDNEXT;
        ST_RDNEXT: if (scl_fall) begin
          sh_q    <= reg_rdata_i;
          cnt_q   <= '0;
          state_q <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state_q == ST_ACK) || (state_q == ST_TX && !sh_q[BYTE_W-1]);

  a_r4_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_det || stop_det)) |-> !scl_s);
  a_r5_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r7_nack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK && scl_rise && sda_s && !start_det && !stop_det) |=>
      (state_q == ST_IDLE && !sda_oe_o));
  a_r2_mismatch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREACK && phase_q == PH_DEV && !match_q && scl_fall && !start_det && !stop_det)
      |=> !sda_oe_o);
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  logic [7:0] wbuf [8];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    else if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  i2c_reg_slave i_i2c_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    if (p <= 8'h3F || p >= 8'h80) return (p == 8'hFF) ? 8'h00 : p + 8'h01;
    return p;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    wclk(3); rst_n = 1'b1; wclk(3);
    for (int i = 0; i < 256; i++) exp_m[i] = 8'(i * 7 + 3);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q); scl = 1'b1; wclk(2 * Q); scl = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
    ack = ~sda_bus;
    wclk(Q); scl = 1'b0; wclk(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wclk(Q); scl = 1'b1; wclk(Q); b = {b[6:0], sda_bus}; wclk(Q); scl = 1'b0; wclk(Q);
    end
    sda_m = ~give_ack; wclk(Q); scl = 1'b1; wclk(2 * Q); scl = 1'b0; wclk(Q); sda_m = 1'b1;
  endtask

  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] q = p;
    bus_start;
    send_byte({dev, 1'b0}, ack); chk("R1 addr ack", ack, 1);
    send_byte(p, ack);           chk("R5 ptr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);   chk("R5 data ack", ack, 1);
      exp_m[q] = wbuf[i];
      q = next_ptr(q);
    end
    bus_stop;
  endtask

  task automatic rd_burst(input logic [6:0] dev, input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] b, q = p;
    bus_start;
    send_byte({dev, 1'b0}, ack); chk("R1 addr ack", ack, 1);
    send_byte(p, ack);           chk("R5 ptr ack", ack, 1);
    bus_start;
    send_byte({dev, 1'b1}, ack); chk("R6 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(req, b, exp_m[q]);
      q = next_ptr(q);
    end
    chk("R7 released after nack", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd2024));
    do_reset(1'b0);
    chk("R11 oe reset", sda_oe, 0);
    chk("R11 we reset", reg_we, 0);
    chk("R11 ptr reset", reg_addr, 0);

    // R3: byte with no START is ignored
    send_byte(8'h80, ack); chk("R3 no start no ack", ack, 0);
    bus_stop;

    // R5 R6 R8: write then read in increment range
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h01;
    wr_burst(7'h40, 8'h10, 3);
    rd_burst(7'h40, 8'h10, 3, "R8 incr read");
    rd_burst(7'h40, 8'h11, 1, "R6 single read");

    // R9: fixed window
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_burst(7'h40, 8'h50, 2);
    rd_burst(7'h40, 8'h50, 3, "R9 fixed read");
    rd_burst(7'h40, 8'h51, 1, "R9 neighbour untouched");

    // R10: wrap
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2;
    wr_burst(7'h40, 8'hFE, 3);
    rd_burst(7'h40, 8'hFF, 2, "R10 wrap read");

    // R2: wrong address, nothing acked or written
    bus_start;
    send_byte({7'h41, 1'b0}, ack); chk("R2 mismatch no ack", ack, 0);
    send_byte(8'h20, ack);         chk("R2 ptr no ack", ack, 0);
    send_byte(8'h99, ack);         chk("R2 data no ack", ack, 0);
    bus_stop;
    rd_burst(7'h40, 8'h20, 1, "R2 no write");

    // R3: after STOP further bytes ignored
    bus_start;
    send_byte({7'h40, 1'b0}, ack); chk("R3 ack before stop", ack, 1);
    bus_stop;
    send_byte(8'h80, ack); chk("R3 after stop no ack", ack, 0);
    bus_stop;

    // random bursts
    for (int t = 0; t < 16; t++) begin
      logic [7:0] p = 8'($urandom);
      int n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(7'h40, p, n);
      rd_burst(7'h40, p, n + 1, "R8 R9 random readback");
    end

    // R1: strap high selects 0x41
    do_reset(1'b1);
    bus_start;
    send_byte({7'h40, 1'b0}, ack); chk("R1 0x40 rejected with strap", ack, 0);
    bus_stop;
    strap = 1'b0;
    wbuf[0] = 8'h5A;
    wr_burst(7'h41, 8'h05, 1);
    rd_burst(7'h41, 8'h05, 1, "R1 strap high access");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule